// File: doc/BRIEF.md
# Linked-Reservation Memory Monitor

This block fronts a small word-addressed memory that several requesters share. Each requester can issue a plain load, a plain store, a load-linked or a store-conditional. One request is accepted per cycle. The response comes back one cycle later, tagged with the requester's index.

For every requester the block keeps one reservation, made of a valid flag and an address. A load-linked reads the word and arms the issuing requester's reservation on that address. A later store-conditional from the same requester commits only if that reservation is still armed on the same address. Any committed write to an address disarms every reservation that points at it. This gives software an atomic read-modify-write built from two separate requests: a competing writer that slips in between them makes the conditional store fail.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads as zero, and no reservation is armed.
- R2: Each cycle at most one requester is granted. The grant goes to the lowest-indexed requester whose `req_valid` is high. A requester keeps its request asserted until it sees its `grant` bit.
- R3: A granted request produces exactly one response in the following cycle: `rsp_valid` is high for one cycle and `rsp_id` is the granted index. With no grant, the next cycle shows no response.
- R4: Op code 0 (load) and op code 2 (load-linked) return the addressed word in `rsp_rdata`. A load-linked also arms the requester's reservation on that address.
- R5: Op code 1 (plain store) writes `req_wdata` to the addressed word. It returns `rsp_rdata` = 0 and `rsp_ok` = 0.
- R6: Op code 3 (store-conditional) succeeds when the requester's reservation is armed on the same address. On success the word is written and `rsp_ok` = 1.
- R7: A store-conditional without an armed reservation, or with one on a different address, leaves memory unchanged and returns `rsp_ok` = 0.
- R8: Every committed write, whether a plain store or a successful conditional store, disarms the reservation of every requester whose reserved address equals the written address.
- R9: A store-conditional always disarms the issuing requester's own reservation, whether it succeeds or fails.
- R10: A new load-linked replaces the issuing requester's earlier reservation.
- R11: When two requesters have linked the same address and present conditional stores in the same cycle, the first one granted succeeds and the other fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 2*NREQ | Op code per requester (0 load, 1 store, 2 load-linked, 3 store-conditional) |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data per requester |
| grant | output | NREQ | One-hot acceptance of a request in this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | $clog2(NREQ) | Index of the requester being answered |
| rsp_rdata | output | DW | Read data for loads and load-linked; zero otherwise |
| rsp_ok | output | 1 | Store-conditional success flag |

## Verification
The bench builds the block with four requesters, a 4-bit address and 16-bit data. Random traffic is confined to four addresses, so links from different requesters often land on the same word and are often broken by other requesters' stores. With four requesters, an index-3 request can be starved by three others, and two simultaneous conditional stores show the priority order. Directed cases cover re-linking to another address and conditional stores made with no link at all.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    grant,
  output logic               rsp_valid,
  output logic [IDW-1:0]     rsp_id,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_ok
);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]  mem   [DEPTH];
  logic [NREQ-1:0] res_v;
  logic [AW-1:0]  res_a [NREQ];

  logic [IDW-1:0] gid;
  logic           any;

  always_comb begin
    grant = '0;
    gid   = '0;
    any   = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_valid[i] && !any) begin
        any      = 1'b1;
        gid      = IDW'(i);
        grant[i] = 1'b1;
      end
    end
  end

  logic [1:0]    s_op;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  assign s_op    = req_op[gid*2 +: 2];
  assign s_addr  = req_addr[gid*AW +: AW];
  assign s_wdata = req_wdata[gid*DW +: DW];

  logic sc_hit, commit, is_read;
  assign sc_hit  = res_v[gid] && (res_a[gid] == s_addr);
  assign commit  = any && ((s_op == OP_ST) || (s_op == OP_SC && sc_hit));
  assign is_read = (s_op == OP_LD) || (s_op == OP_LL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
      res_v     <= '0;
      for (int i = 0; i < NREQ; i++) res_a[i] <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      rsp_valid <= any;
      if (any) begin
        rsp_id    <= gid;
        rsp_rdata <= is_read ? mem[s_addr] : '0;
        rsp_ok    <= (s_op == OP_SC) && sc_hit;
      end else begin
        rsp_ok    <= 1'b0;
      end
      if (commit) mem[s_addr] <= s_wdata;
      for (int i = 0; i < NREQ; i++) begin
        if (commit && res_v[i] && res_a[i] == s_addr) res_v[i] <= 1'b0;
        if (any && IDW'(i) == gid && s_op == OP_SC) res_v[i] <= 1'b0;
        if (any && IDW'(i) == gid && s_op == OP_LL) begin
          res_v[i] <= 1'b1;
          res_a[i] <= s_addr;
        end
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ = 4,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] grant,
  input logic            rsp_valid,
  input logic [IDW-1:0]  rsp_id,
  input logic            rsp_ok
);
  logic [NREQ-1:0] g_q;
  always_ff @(posedge clk) g_q <= rst_n ? grant : '0;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r2_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);
  a_r2_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> (|grant));
  a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (((grant - 1'b1) & req_valid) == '0));
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_valid);
  a_r3_id_matches: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> g_q[rsp_id]);
  a_r6_ok_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .IDW(IDW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ok(rsp_ok));

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int NREQ = 4, AW = 4, DW = 16, IDW = 2, DEPTH = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0] req_valid = '0;
  logic [2*NREQ-1:0] req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0] grant;
  logic rsp_valid, rsp_ok;
  logic [IDW-1:0] rsp_id;
  logic [DW-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (.*);

  int checks = 0, fails = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic m_rv [NREQ];
  logic [AW-1:0] m_ra [NREQ];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sc(input int id, input logic [AW-1:0] a);
    return m_rv[id] && m_ra[id] == a;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [1:0] op, input logic [AW-1:0] a);
    return (op == 2'd0 || op == 2'd2) ? m_mem[a] : '0;
  endfunction

  task automatic model(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    logic wr;
    wr = (op == 2'd1) || (op == 2'd3 && exp_sc(id, a));
    if (wr) begin
      m_mem[a] = d;
      for (int i = 0; i < NREQ; i++) if (m_rv[i] && m_ra[i] == a) m_rv[i] = 0;
    end
    if (op == 2'd3) m_rv[id] = 0;
    if (op == 2'd2) begin m_rv[id] = 1; m_ra[id] = a; end
  endtask

  task automatic put(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    req_valid[id] = 1;
    req_op[id*2 +: 2] = op;
    req_addr[id*AW +: AW] = a;
    req_wdata[id*DW +: DW] = d;
  endtask

  task automatic do_op(input int id, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string req);
    logic [DW-1:0] er;
    logic eo;
    @(negedge clk);
    chk("R3 pulse ends", {31'd0, rsp_valid}, 0);
    put(id, op, a, d);
    #1;
    chk("R2 grant", {28'd0, grant}, 32'(1 << id));
    er = exp_rd(op, a);
    eo = (op == 2'd3) && exp_sc(id, a);
    model(id, op, a, d);
    @(negedge clk);
    req_valid = '0;
    chk("R3 rsp_valid", {31'd0, rsp_valid}, 1);
    chk("R3 rsp_id", {30'd0, rsp_id}, id);
    chk(req, {16'd0, rsp_rdata}, {16'd0, er});
    chk(req, {31'd0, rsp_ok}, {31'd0, eo});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    for (int i = 0; i < NREQ; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset no rsp", {31'd0, rsp_valid}, 0);
    do_op(0, 2'd0, 4'd5, 0, "R1 mem zero");
    do_op(1, 2'd3, 4'd0, 16'h1111, "R1 R7 no link fails");
    do_op(1, 2'd0, 4'd0, 0, "R7 memory unchanged");

    do_op(2, 2'd1, 4'd3, 16'hBEEF, "R5 store");
    do_op(3, 2'd2, 4'd3, 0, "R4 load-linked data");
    do_op(3, 2'd3, 4'd3, 16'hCAFE, "R6 sc success");
    do_op(0, 2'd0, 4'd3, 0, "R6 written");
    do_op(3, 2'd3, 4'd3, 16'h0BAD, "R9 own link cleared");

    do_op(0, 2'd2, 4'd7, 0, "R4 link");
    do_op(1, 2'd1, 4'd7, 16'h0077, "R5 store by other");
    do_op(0, 2'd3, 4'd7, 16'h9999, "R8 link broken");
    do_op(0, 2'd0, 4'd7, 0, "R8 value kept");

    do_op(2, 2'd2, 4'd8, 0, "R4 link a");
    do_op(2, 2'd2, 4'd9, 0, "R10 relink");
    do_op(2, 2'd3, 4'd8, 16'h0008, "R10 old address fails");
    do_op(2, 2'd2, 4'd8, 0, "R4 link again");
    do_op(2, 2'd3, 4'd9, 16'h0009, "R7 wrong address");
    do_op(2, 2'd3, 4'd8, 16'h0808, "R9 failed sc cleared link");

    do_op(1, 2'd2, 4'd2, 0, "R11 link 1");
    do_op(2, 2'd2, 4'd2, 0, "R11 link 2");
    @(negedge clk);
    put(1, 2'd3, 4'd2, 16'h0101);
    put(2, 2'd3, 4'd2, 16'h0202);
    #1 chk("R11 R2 lower first", {28'd0, grant}, 32'b0010);
    @(negedge clk);
    req_valid[1] = 0;
    chk("R11 first ok", {31'd0, rsp_ok}, 1);
    #1 chk("R11 R2 second granted", {28'd0, grant}, 32'b0100);
    @(negedge clk);
    req_valid = '0;
    chk("R11 second fails", {31'd0, rsp_ok}, 0);
    chk("R11 second id", {30'd0, rsp_id}, 2);
    m_mem[2] = 16'h0101; m_rv[1] = 0; m_rv[2] = 0;
    do_op(3, 2'd0, 4'd2, 0, "R11 memory holds first");

    @(negedge clk);
    put(3, 2'd0, 4'd1, 0);
    put(1, 2'd0, 4'd1, 0);
    #1 chk("R2 priority", {28'd0, grant}, 32'b0010);
    @(negedge clk);
    req_valid = '0;
    chk("R3 id", {30'd0, rsp_id}, 1);
    @(negedge clk);
    chk("R3 idle", {31'd0, rsp_valid}, 0);

    for (int n = 0; n < 600; n++) begin
      int id;
      logic [1:0] op;
      logic [AW-1:0] a;
      id = $urandom_range(NREQ - 1, 0);
      op = 2'($urandom_range(3, 0));
      a = AW'($urandom_range(3, 0));
      do_op(id, op, a, DW'($urandom), "R4 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule